// File: doc/BRIEF.md
# Lithium Cell Charge Profile Sequencer

This block is the digital controller that moves a single-cell lithium battery through its charging phases. Analog comparators outside the block turn battery voltage and charge current into logic flags. The block reads these flags together with qualification inputs, configuration bits and a slow time tick. It then chooses the active phase, the charge-current setpoint the analog loop regulates to, and whether the charger runs at all. It raises a soft-start request when fast charging starts, and it emits single-cycle event pulses that an interrupt controller can latch.

A phase change happens only after its triggering flag has stayed true for a fixed number of ticks, so short glitches on a comparator are ignored. Three safety timers guard the pre-charge phase, the fast-charge phase and the top-off phase. The first two end in a fault. The top-off timer ends in a done state, which either stops the charger or keeps it in constant voltage, depending on a configuration bit. Each duration is a count of `tick` pulses. Minute-scale durations are counted through the `MIN_TICKS` parameter, which sets how many ticks make one minute. With a tick of 1 ms, the default of 60000 gives real time.

Top module: `chg_seq`

## Requirements
- R1: After reset, or while `vin_ok` is low, the phase is WAIT. Once `vin_ok` has stayed high for START_TICKS+WAIT_TICKS (220+27) ticks, the block enters TRICKLE if qualified and SUSP if not. No event is raised on this exit.
- R2: TRICKLE moves to PRE only after `bat_gt_trk` has been high for DEGLITCH_TICKS (7) consecutive ticks. A drop of the flag restarts the count.
- R3: PRE moves to FAST after `bat_gt_sysmin` has been high for 7 consecutive ticks. On that transition `soft_start` is high for SOFTSTART_TICKS (2) ticks, and `soft_start` is never high outside FAST.
- R4: The pre-charge timer runs only in PRE and is cleared on leaving PRE. If it reaches 45 minutes, the phase becomes FAULT and `evt_fault` pulses.
- R5: The fast-charge timer runs only in FAST. `fast_tmr_sel` picks the limit: 0 = 210 min, 1 = 270 min, 2 = 330 min, 3 = off. The timer is also off while `ilim_is_100` is high. When it expires, the phase becomes FAULT and `evt_fault` pulses.
- R6: FAST moves to CV on the clock after `bat_at_reg` is seen high. CV moves to TOPOFF after `ichg_lt_topoff` has been high for 7 ticks, and `evt_topoff` pulses on that move.
- R7: The top-off timer limit is 10+5*`topoff_tmr_sel` minutes. When it expires, the phase becomes DONE and `evt_done` pulses. In DONE, `stop_at_done`=1 gives `chg_on`=0 with a zero setpoint, and `stop_at_done`=0 keeps the fast (constant-voltage) setpoint with `chg_on`=1.
- R8: From TOPOFF or DONE, when `bat_lt_rch` has been high for RECHG_TICKS (27) consecutive ticks, the phase returns to FAST. `evt_rch` pulses and `soft_start` stays low. A shorter high period changes nothing and raises no event.
- R9: In any charging phase (TRICKLE to DONE), qualification is lost when any of these holds: `charge_enable`=0, `chg_suspend`=1, `chg_off_pin`=1, `bat_present`=0, `vin_ovp`=1, `bat_ovp`=1 or `die_hot`=1. The next clock then gives SUSP and an `evt_susp` pulse. SUSP moves to TRICKLE on the clock after qualification returns.
- R10: FAULT is held until one of three things happens: `charge_enable` changes value, `chg_off_pin` changes value (each of these leads to SUSP), or `vin_ok` falls (which leads to WAIT). Other qualification changes have no effect on FAULT.
- R11: `phase` encodes WAIT=0, TRICKLE=1, PRE=2, FAST=3, CV=4, TOPOFF=5, DONE=6, SUSP=7, FAULT=8. `isel` encodes zero=0, trickle=1, pre=2, fast=3. It reads 1 in TRICKLE, 2 in PRE, 3 in FAST/CV/TOPOFF and in DONE without stop, and 0 otherwise. `chg_on` is high exactly when `isel` is non-zero.
- R12: Each event output is a single-cycle pulse that coincides with the first cycle of the new phase, and no two events are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base pulse, one per tick |
| vin_ok | input | 1 | Input source attached and above lockout |
| charge_enable | input | 1 | Software charge enable |
| chg_suspend | input | 1 | Software suspend request |
| chg_off_pin | input | 1 | Hardware charger disable pin, high disables |
| bat_present | input | 1 | Battery detected |
| vin_ovp | input | 1 | Input overvoltage |
| bat_ovp | input | 1 | Battery overvoltage |
| die_hot | input | 1 | Die temperature out of range |
| bat_gt_trk | input | 1 | Battery above trickle exit level |
| bat_gt_sysmin | input | 1 | Battery above minimum system level |
| bat_at_reg | input | 1 | Battery at regulation voltage |
| ichg_lt_topoff | input | 1 | Charge current below top-off level |
| bat_lt_rch | input | 1 | Battery below recharge level |
| fast_tmr_sel | input | 2 | Fast-charge timer limit select |
| ilim_is_100 | input | 1 | Input current limit set to 100 mA |
| topoff_tmr_sel | input | 3 | Top-off timer limit select |
| stop_at_done | input | 1 | Turn the charger off when top-off ends |
| phase | output | 4 | Current phase code |
| isel | output | 2 | Charge-current setpoint select |
| soft_start | output | 1 | Soft-start request |
| chg_on | output | 1 | Charger enable |
| evt_susp | output | 1 | Qualification lost event |
| evt_fault | output | 1 | Safety timer fault event |
| evt_topoff | output | 1 | Top-off reached event |
| evt_done | output | 1 | Top-off timer done event |
| evt_rch | output | 1 | Recharge started event |

## Verification
A corrupted phase register shows at once on `phase`, and on the same cycle on `isel` and `chg_on`, because both are decoded from the phase without any further register. A dwell counter that does not clear, or that ends one count early or late, moves the phase transition by exactly that many cycles. The bench therefore samples one cycle before and one cycle after each expected edge. A safety timer with the wrong limit, or one that is not cleared on leaving its phase, turns up as an early or missing FAULT or DONE. A fault that clears itself turns up as the phase leaving FAULT without a toggle.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [3:0] {
    PH_WAIT    = 4'd0,
    PH_TRICKLE = 4'd1,
    PH_PRE     = 4'd2,
    PH_FAST    = 4'd3,
    PH_CV      = 4'd4,
    PH_TOPOFF  = 4'd5,
    PH_DONE    = 4'd6,
    PH_SUSP    = 4'd7,
    PH_FAULT   = 4'd8
  } phase_e;

  typedef enum logic [1:0] {
    SP_ZERO    = 2'd0,
    SP_TRICKLE = 2'd1,
    SP_PRE     = 2'd2,
    SP_FAST    = 2'd3
  } setp_e;

  // longest fast-charge limit, used to size the shared timer width
  localparam int FAST_MAX_MIN = 330;

  // fast-charge limit in minutes; zero means the timer is off
  function automatic int fast_minutes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 210;
      2'd1:    return 270;
      2'd2:    return 330;
      default: return 0;
    endcase
  endfunction

  // top-off limit in minutes, 10 to 45 in 5 minute steps
  function automatic int topoff_minutes(input logic [2:0] sel);
    return 10 + 5 * int'(sel);
  endfunction

  // setpoint chosen for a phase
  function automatic setp_e setp_for(input phase_e ph, input logic stop);
    case (ph)
      PH_TRICKLE:                 return SP_TRICKLE;
      PH_PRE:                     return SP_PRE;
      PH_FAST, PH_CV, PH_TOPOFF:  return SP_FAST;
      PH_DONE:                    return stop ? SP_ZERO : SP_FAST;
      default:                    return SP_ZERO;
    endcase
  endfunction

  function automatic logic is_charging(input phase_e ph);
    return ph inside {PH_TRICKLE, PH_PRE, PH_FAST, PH_CV, PH_TOPOFF, PH_DONE};
  endfunction

endpackage

// File: rtl/chg_dwell.sv
// Counts ticks while a condition holds in an enabled phase; met after N ticks.
module chg_dwell #(
  parameter int N = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic cond,
  output logic met
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;
  logic          live;

  assign live = en && cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!live)                     cnt <= '0;
    else if (tick && cnt != CW'(N))     cnt <= cnt + 1'b1;
  end

  assign met = live && (cnt == CW'(N));

  // a broken hold must restart the count (glitch rejection)
  assert_dwell_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> cnt == '0)
    else $error("dwell count kept after condition dropped");

endmodule

// File: rtl/chg_safety_tmr.sv
// Safety timer: runs while enabled, cleared when not, expired at the limit.
module chg_safety_tmr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);

  // a timer that is stopped starts from zero next time (timers reset on exit)
  assert_tmr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0)
    else $error("safety timer not cleared when stopped");

endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_seq_pkg::*;
#(
  parameter int MIN_TICKS       = 60000,
  parameter int START_TICKS     = 220,
  parameter int WAIT_TICKS      = 27,
  parameter int DEGLITCH_TICKS  = 7,
  parameter int RECHG_TICKS     = 27,
  parameter int SOFTSTART_TICKS = 2,
  parameter int PRE_MIN         = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vin_ok,
  input  logic       charge_enable,
  input  logic       chg_suspend,
  input  logic       chg_off_pin,
  input  logic       bat_present,
  input  logic       vin_ovp,
  input  logic       bat_ovp,
  input  logic       die_hot,
  input  logic       bat_gt_trk,
  input  logic       bat_gt_sysmin,
  input  logic       bat_at_reg,
  input  logic       ichg_lt_topoff,
  input  logic       bat_lt_rch,
  input  logic [1:0] fast_tmr_sel,
  input  logic       ilim_is_100,
  input  logic [2:0] topoff_tmr_sel,
  input  logic       stop_at_done,
  output logic [3:0] phase,
  output logic [1:0] isel,
  output logic       soft_start,
  output logic       chg_on,
  output logic       evt_susp,
  output logic       evt_fault,
  output logic       evt_topoff,
  output logic       evt_done,
  output logic       evt_rch
);
  localparam int TW  = $clog2(FAST_MAX_MIN * MIN_TICKS + 1);
  localparam int SSW = $clog2(SOFTSTART_TICKS + 1);

  phase_e         ph, ph_n;
  logic           qual_ok, toggle, fast_on;
  logic           en_q, off_q;
  logic           start_met, trk_met, sys_met, top_met, rch_met;
  logic           pre_exp, fast_exp, topoff_exp;
  logic [TW-1:0]  pre_lim, fast_lim, topoff_lim;
  logic [SSW-1:0] ss_cnt;
  logic           ss_load;
  logic           ev_susp, ev_fault, ev_topoff, ev_done, ev_rch;

  // qualification and fault-clear sources
  assign qual_ok = charge_enable && !chg_suspend && !chg_off_pin && bat_present &&
                   !vin_ovp && !bat_ovp && !die_hot;
  assign toggle  = (charge_enable != en_q) || (chg_off_pin != off_q);
  assign fast_on = (fast_tmr_sel != 2'b11) && !ilim_is_100;

  // dwell (deglitch) counters
  chg_dwell #(.N(START_TICKS + WAIT_TICKS)) u_start (
    .clk, .rst_n, .tick, .en(ph == PH_WAIT), .cond(vin_ok), .met(start_met));
  chg_dwell #(.N(DEGLITCH_TICKS)) u_trk (
    .clk, .rst_n, .tick, .en(ph == PH_TRICKLE), .cond(bat_gt_trk), .met(trk_met));
  chg_dwell #(.N(DEGLITCH_TICKS)) u_sys (
    .clk, .rst_n, .tick, .en(ph == PH_PRE), .cond(bat_gt_sysmin), .met(sys_met));
  chg_dwell #(.N(DEGLITCH_TICKS)) u_top (
    .clk, .rst_n, .tick, .en(ph == PH_CV), .cond(ichg_lt_topoff), .met(top_met));
  chg_dwell #(.N(RECHG_TICKS)) u_rch (
    .clk, .rst_n, .tick, .en(ph == PH_TOPOFF || ph == PH_DONE), .cond(bat_lt_rch),
    .met(rch_met));

  // safety timers
  assign pre_lim    = TW'(PRE_MIN * MIN_TICKS);
  assign fast_lim   = TW'(fast_minutes(fast_tmr_sel) * MIN_TICKS);
  assign topoff_lim = TW'(topoff_minutes(topoff_tmr_sel) * MIN_TICKS);

  chg_safety_tmr #(.W(TW)) u_pre_tmr (
    .clk, .rst_n, .tick, .run(ph == PH_PRE), .limit(pre_lim), .expired(pre_exp));
  chg_safety_tmr #(.W(TW)) u_fast_tmr (
    .clk, .rst_n, .tick, .run(ph == PH_FAST && fast_on), .limit(fast_lim),
    .expired(fast_exp));
  chg_safety_tmr #(.W(TW)) u_top_tmr (
    .clk, .rst_n, .tick, .run(ph == PH_TOPOFF), .limit(topoff_lim),
    .expired(topoff_exp));

  // next phase and events
  always_comb begin
    ph_n      = ph;
    ss_load   = 1'b0;
    ev_susp   = 1'b0;
    ev_fault  = 1'b0;
    ev_topoff = 1'b0;
    ev_done   = 1'b0;
    ev_rch    = 1'b0;
    if (!vin_ok) begin
      ph_n = PH_WAIT;
    end else begin
      case (ph)
        PH_WAIT:  if (start_met) ph_n = qual_ok ? PH_TRICKLE : PH_SUSP;
        PH_SUSP:  if (qual_ok) ph_n = PH_TRICKLE;
        PH_FAULT: if (toggle) ph_n = PH_SUSP;
        default: begin
          if (!qual_ok) begin
            ph_n    = PH_SUSP;
            ev_susp = 1'b1;
          end else begin
            case (ph)
              PH_TRICKLE: if (trk_met) ph_n = PH_PRE;
              PH_PRE: begin
                if (pre_exp) begin
                  ph_n     = PH_FAULT;
                  ev_fault = 1'b1;
                end else if (sys_met) begin
                  ph_n    = PH_FAST;
                  ss_load = 1'b1;
                end
              end
              PH_FAST: begin
                if (bat_at_reg) begin
                  ph_n = PH_CV;
                end else if (fast_exp) begin
                  ph_n     = PH_FAULT;
                  ev_fault = 1'b1;
                end
              end
              PH_CV: begin
                if (top_met) begin
                  ph_n      = PH_TOPOFF;
                  ev_topoff = 1'b1;
                end
              end
              PH_TOPOFF: begin
                if (rch_met) begin
                  ph_n   = PH_FAST;
                  ev_rch = 1'b1;
                end else if (topoff_exp) begin
                  ph_n    = PH_DONE;
                  ev_done = 1'b1;
                end
              end
              PH_DONE: begin
                if (rch_met) begin
                  ph_n   = PH_FAST;
                  ev_rch = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_WAIT;
      en_q       <= 1'b0;
      off_q      <= 1'b0;
      ss_cnt     <= '0;
      evt_susp   <= 1'b0;
      evt_fault  <= 1'b0;
      evt_topoff <= 1'b0;
      evt_done   <= 1'b0;
      evt_rch    <= 1'b0;
    end else begin
      ph         <= ph_n;
      en_q       <= charge_enable;
      off_q      <= chg_off_pin;
      evt_susp   <= ev_susp;
      evt_fault  <= ev_fault;
      evt_topoff <= ev_topoff;
      evt_done   <= ev_done;
      evt_rch    <= ev_rch;
      if (ss_load)                    ss_cnt <= SSW'(SOFTSTART_TICKS);
      else if (ph_n != PH_FAST)       ss_cnt <= '0;
      else if (tick && ss_cnt != '0)  ss_cnt <= ss_cnt - 1'b1;
    end
  end

  // outputs
  assign phase      = ph;
  assign isel       = setp_for(ph, stop_at_done);
  assign chg_on     = is_charging(ph) && !(ph == PH_DONE && stop_at_done);
  assign soft_start = (ss_cnt != '0);

  // assertions
  assert_evt_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_susp, evt_fault, evt_topoff, evt_done, evt_rch}))
    else $error("more than one event at once");

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FAULT && vin_ok && !toggle) |=> ph == PH_FAULT)
    else $error("fault left without a clear source");

  assert_pre_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PRE && $past(ph) != PH_PRE) |-> $past(ph) == PH_TRICKLE)
    else $error("pre-charge entered from a phase other than trickle");

  assert_ss_in_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |-> ph == PH_FAST)
    else $error("soft start outside fast charge");

  assert_susp_on_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_ok && !qual_ok && is_charging(ph)) |=> (ph == PH_SUSP && evt_susp))
    else $error("qualification loss did not suspend");

  assert_fast_tmr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_tmr_sel == 2'b11 || ilim_is_100) |-> !fast_exp)
    else $error("disabled fast timer expired");

  assert_done_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DONE && $past(ph) == PH_TOPOFF) |-> evt_done)
    else $error("done entered without done event");

  assert_rch_no_ss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rch |-> (!soft_start && ph == PH_FAST))
    else $error("recharge with soft start or wrong phase");

  assert_off_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_on |-> isel == SP_ZERO)
    else $error("setpoint non-zero with charger off");

endmodule

// File: tb/sim_chg_seq.sv
`timescale 1ns/1ps
module sim_chg_seq;

  localparam int P_WAIT = 0, P_TRK = 1, P_PRE = 2, P_FAST = 3, P_CV = 4,
                 P_TOP = 5, P_DONE = 6, P_SUSP = 7, P_FAULT = 8;
  localparam int MT = 2;   // ticks per minute in this bench

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic vin_ok = 1'b1, charge_enable = 1'b1, chg_suspend = 1'b0, chg_off_pin = 1'b0;
  logic bat_present = 1'b1, vin_ovp = 1'b0, bat_ovp = 1'b0, die_hot = 1'b0;
  logic bat_gt_trk = 1'b0, bat_gt_sysmin = 1'b0, bat_at_reg = 1'b0;
  logic ichg_lt_topoff = 1'b0, bat_lt_rch = 1'b0;
  logic [1:0] fast_tmr_sel = 2'b11;
  logic ilim_is_100 = 1'b0;
  logic [2:0] topoff_tmr_sel = 3'd0;
  logic stop_at_done = 1'b1;
  logic [3:0] phase;
  logic [1:0] isel;
  logic soft_start, chg_on, evt_susp, evt_fault, evt_topoff, evt_done, evt_rch;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chg_seq #(.MIN_TICKS(MT)) u0 (
    .clk, .rst_n, .tick, .vin_ok, .charge_enable, .chg_suspend, .chg_off_pin,
    .bat_present, .vin_ovp, .bat_ovp, .die_hot, .bat_gt_trk, .bat_gt_sysmin,
    .bat_at_reg, .ichg_lt_topoff, .bat_lt_rch, .fast_tmr_sel, .ilim_is_100,
    .topoff_tmr_sel, .stop_at_done, .phase, .isel, .soft_start, .chg_on,
    .evt_susp, .evt_fault, .evt_topoff, .evt_done, .evt_rch);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ph(input string tag, input int exp);
    chk(int'(phase) == exp, tag, int'(phase), exp);
  endtask

  function automatic int exp_isel(input int ph, input bit stop);
    if (ph == P_TRK) return 1;
    if (ph == P_PRE) return 2;
    if (ph >= P_FAST && ph <= P_TOP) return 3;
    if (ph == P_DONE) return stop ? 0 : 3;
    return 0;
  endfunction

  function automatic int evt_count();
    return int'(evt_susp) + int'(evt_fault) + int'(evt_topoff) + int'(evt_done) + int'(evt_rch);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd4242));
    cyc(3);
    // R1 reset state, R11 outputs in WAIT
    chk_ph("R1 reset phase", P_WAIT);
    chk(isel == 2'd0 && !chg_on, "R11 reset setpoint", int'(isel), 0);
    chk(evt_count() == 0 && !soft_start, "R12 reset events", evt_count(), 0);
    rst_n = 1'b1;
    cyc(247);
    chk_ph("R1 still waiting", P_WAIT);
    cyc(1);
    chk_ph("R1 start window done", P_TRK);
    chk(int'(isel) == 1 && chg_on, "R11 trickle setpoint", int'(isel), 1);

    // R2 glitch on trickle flag restarts the count
    bat_gt_trk = 1'b1; cyc(5);
    bat_gt_trk = 1'b0; cyc(1);
    bat_gt_trk = 1'b1; cyc(7);
    chk_ph("R2 glitch restarted dwell", P_TRK);
    cyc(1);
    chk_ph("R2 trickle to pre", P_PRE);
    chk(int'(isel) == 2, "R11 pre setpoint", int'(isel), 2);

    // R3 pre to fast with soft start
    bat_gt_sysmin = 1'b1; cyc(7);
    chk_ph("R3 still pre", P_PRE);
    cyc(1);
    chk_ph("R3 pre to fast", P_FAST);
    chk(soft_start == 1'b1, "R3 soft start first tick", int'(soft_start), 1);
    cyc(1);
    chk(soft_start == 1'b1, "R3 soft start second tick", int'(soft_start), 1);
    cyc(1);
    chk(soft_start == 1'b0, "R3 soft start ends", int'(soft_start), 0);

    // R9 qualification loss and resume
    charge_enable = 1'b0; cyc(1);
    chk_ph("R9 suspend", P_SUSP);
    chk(evt_susp == 1'b1, "R9 suspend event", int'(evt_susp), 1);
    chk(isel == 2'd0 && !chg_on, "R11 suspend setpoint", int'(isel), 0);
    cyc(1);
    chk(evt_susp == 1'b0, "R12 event single cycle", int'(evt_susp), 0);
    charge_enable = 1'b1; cyc(1);
    chk_ph("R9 resume", P_TRK);
    cyc(8);
    chk_ph("R2 re-enter pre", P_PRE);
    cyc(8);
    chk_ph("R3 re-enter fast", P_FAST);

    // R5 fast timer forced off by 100 mA limit, then expiry
    fast_tmr_sel = 2'd0; ilim_is_100 = 1'b1;
    cyc(500);
    chk_ph("R5 timer off at 100 mA", P_FAST);
    ilim_is_100 = 1'b0;
    cyc(210 * MT);
    chk_ph("R5 before fast expiry", P_FAST);
    cyc(1);
    chk_ph("R5 fast timer fault", P_FAULT);
    chk(evt_fault == 1'b1, "R5 fault event", int'(evt_fault), 1);
    chk(!chg_on && isel == 2'd0, "R11 fault setpoint", int'(chg_on), 0);

    // R10 fault holds against non-clearing changes
    cyc(20);
    chg_suspend = 1'b1; cyc(2);
    chg_suspend = 1'b0; cyc(2);
    chk_ph("R10 fault held", P_FAULT);
    chg_off_pin = 1'b1; cyc(1);
    chk_ph("R10 pin toggle clears", P_SUSP);
    chg_off_pin = 1'b0; fast_tmr_sel = 2'b11; cyc(1);
    chk_ph("R9 resume after fault", P_TRK);
    cyc(16);
    chk_ph("R3 fast again", P_FAST);

    // R6 regulation and top-off
    bat_at_reg = 1'b1; cyc(1);
    chk_ph("R6 fast to cv", P_CV);
    ichg_lt_topoff = 1'b1; cyc(7);
    chk_ph("R6 cv held", P_CV);
    cyc(1);
    chk_ph("R6 top-off", P_TOP);
    chk(evt_topoff == 1'b1, "R6 top-off event", int'(evt_topoff), 1);

    // R7 top-off timer, code 0 = 10 min
    cyc(10 * MT);
    chk_ph("R7 before top-off expiry", P_TOP);
    cyc(1);
    chk_ph("R7 done", P_DONE);
    chk(evt_done == 1'b1, "R7 done event", int'(evt_done), 1);
    chk(!chg_on && isel == 2'd0, "R7 stop at done", int'(chg_on), 0);
    stop_at_done = 1'b0; cyc(1);
    chk(chg_on && int'(isel) == 3, "R7 stay in cv", int'(isel), 3);

    // R8 recharge glitch then real recharge
    seen = 0;
    bat_lt_rch = 1'b1;
    for (int i = 0; i < 20; i++) begin cyc(1); if (evt_rch) seen = 1; end
    bat_lt_rch = 1'b0; cyc(1);
    if (evt_rch) seen = 1;
    chk(!seen, "R8 no event on short dip", int'(seen), 0);
    chk_ph("R8 stays done", P_DONE);
    bat_lt_rch = 1'b1; cyc(27);
    chk_ph("R8 before recharge", P_DONE);
    cyc(1);
    chk_ph("R8 recharge to fast", P_FAST);
    chk(evt_rch == 1'b1, "R8 recharge event", int'(evt_rch), 1);
    chk(soft_start == 1'b0, "R8 no soft start", int'(soft_start), 0);

    // R1 detach, unqualified start
    vin_ok = 1'b0; cyc(1);
    chk_ph("R1 detach to wait", P_WAIT);
    bat_lt_rch = 1'b0; bat_at_reg = 1'b0; ichg_lt_topoff = 1'b0;
    bat_gt_trk = 1'b0; bat_gt_sysmin = 1'b0; bat_present = 1'b0;
    stop_at_done = 1'b1; vin_ok = 1'b1;
    cyc(248);
    chk_ph("R1 unqualified start", P_SUSP);
    chk(evt_susp == 1'b0, "R1 no event on start", int'(evt_susp), 0);
    bat_present = 1'b1; cyc(1);
    chk_ph("R9 battery back", P_TRK);

    // R4 pre-charge timer
    bat_gt_trk = 1'b1; cyc(8);
    chk_ph("R2 pre for timer", P_PRE);
    cyc(45 * MT);
    chk_ph("R4 before pre expiry", P_PRE);
    cyc(1);
    chk_ph("R4 pre timer fault", P_FAULT);
    chk(evt_fault == 1'b1, "R4 fault event", int'(evt_fault), 1);
    charge_enable = 1'b0; cyc(1);
    chk_ph("R10 enable toggle clears", P_SUSP);
    charge_enable = 1'b1; cyc(1);
    chk_ph("R9 resume after enable", P_TRK);

    // random stress: R11, R12, R3 invariants
    for (int i = 0; i < 3000; i++) begin
      tick           = ($urandom % 4) != 0;
      vin_ok         = ($urandom % 128) != 0;
      charge_enable  = ($urandom % 64) != 0;
      chg_suspend    = ($urandom % 64) == 0;
      chg_off_pin    = ($urandom % 64) == 0;
      bat_present    = ($urandom % 64) != 0;
      die_hot        = ($urandom % 128) == 0;
      bat_gt_trk     = ($urandom % 8) != 0;
      bat_gt_sysmin  = ($urandom % 8) != 0;
      bat_at_reg     = ($urandom % 16) == 0;
      ichg_lt_topoff = ($urandom % 4) != 0;
      bat_lt_rch     = ($urandom % 4) == 0;
      fast_tmr_sel   = 2'($urandom);
      ilim_is_100    = 1'($urandom);
      topoff_tmr_sel = 3'($urandom);
      stop_at_done   = 1'($urandom);
      cyc(1);
      chk(int'(isel) == exp_isel(int'(phase), stop_at_done), "R11 random setpoint",
          int'(isel), exp_isel(int'(phase), stop_at_done));
      chk(chg_on == (exp_isel(int'(phase), stop_at_done) != 0), "R11 random enable",
          int'(chg_on), int'(exp_isel(int'(phase), stop_at_done) != 0));
      chk(evt_count() <= 1, "R12 random events", evt_count(), 1);
      chk(!soft_start || int'(phase) == P_FAST, "R3 random soft start",
          int'(phase), P_FAST);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule